// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial EEPROM. It samples the SCL and SDA bus lines with a system clock that runs at least eight times faster than SCL. It drives SDA only through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The block recognises bus START and STOP events and compares the device address byte against its strap pins. It then takes a two-byte word address and either stores incoming bytes in a synchronous RAM model or returns bytes from that RAM.

One address pointer serves both directions. Writes advance the pointer inside the current 32-byte page. Reads advance it across the whole array and wrap from the last byte to byte 0. A read that carries no word address therefore resumes at the byte after the last one touched. A busy input from an external write-cycle timer makes the block refuse its device address, so a host can poll until the write cycle ends. A START anywhere restarts the address phase.

The bus has no flow control beyond the acknowledge bit, so no valid/ready handshake is used. The master throttles the transfer through SCL, and the slave refuses a transfer by leaving SDA released in the acknowledge slot.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` is low and the engine waits for a START; bus activity before a START gets no acknowledge.
- R2: A START is SDA falling while SCL is high, and it can occur at any point. It aborts the command in progress and restarts reception of a device address byte. A STOP is SDA rising while SCL is high, and it returns the engine to idle with SDA released.
- R3: The device address byte is sent MSB first as bits 7..4 = 1010, bits 3..1 = `dev_sel[2:0]` and bit 0 = R/W, where 1 means read. Only a match is acknowledged. After a mismatch, every further byte gets no acknowledge until the next START, and the pointer is unchanged.
- R4: While `busy_i` is high, a matching device address is not acknowledged.
- R5: After each byte it receives, the slave pulls SDA low for the whole ninth SCL clock.
- R6: After a write-direction device address come two word-address bytes, high byte first. Only the low ADDR_W bits are kept, and the upper bits are ignored.
- R7: Each later data byte is stored at the pointer. The pointer's low PAGE_W bits then increment and wrap to the start of the same page, while the upper bits stay fixed.
- R8: A random read is a write command that stops after the word address, then a repeated START with R/W = 1. It returns the byte at the loaded address.
- R9: A read with no word address returns the byte at the last accessed address plus one.
- R10: In a read, each master ACK (SDA low in the ninth clock) fetches the next byte. The address wraps from 2^ADDR_W-1 to 0. A master NACK ends the transfer.
- R11: During a read, each data bit is driven after an SCL falling edge, and SDA is released throughout the master's acknowledge slot.
- R12: A START in the middle of a data byte discards that byte, so memory is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_sel | input | 3 | Strap value for device address bits 3..1 |
| busy_i | input | 1 | Write cycle in progress; address is refused |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
A wrong bit count or a wrong state shows up at the very next acknowledge slot as a missing or misplaced acknowledge, or as SDA held low, within one byte time. A wrong pointer shows up as a wrong byte on the next read. Page wrap, whole-array wrap and pointer carry-over from one command to the next are each exercised, so an off-by-one in the pointer is seen in the first byte read after it. An abort that still lets a write through is caught by reading the aborted address back.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AH,
    ST_AL,
    ST_WR,
    ST_RD
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  // index 1 = SCL, index 0 = SDA
  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prv;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic m1, m2, m3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= 1'b1;
        m2 <= 1'b1;
        m3 <= 1'b1;
      end else begin
        m1 <= raw[g];
        m2 <= m1;
        m3 <= m2;
      end
    end
    assign cur[g] = m2;
    assign prv[g] = m3;
  end

  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~prv[1];
  assign scl_fall  = ~cur[1] & prv[1];
  assign start_det = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign stop_det  = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/twi_eeprom_ram.sv
module twi_eeprom_ram #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twi_eeprom_fsm.sv
module twi_eeprom_fsm
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        dev_sel,
  input  logic              busy_i,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              sda_oe
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] P_ONE = 1;
  localparam logic [ADDR_W-1:0] A_ONE = 1;

  twi_state_e       state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             rw;
  logic             mack;
  logic [HI_W-1:0]  addr_hi;
  logic             dev_match;

  assign dev_match = (shreg[7:1] == {DEV_TYPE, dev_sel}) && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      addr_hi   <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            if (state != ST_RD) shreg <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (state == ST_RD) mack <= ~sda_s;
          end
        end else if (scl_fall) begin
          if (state == ST_RD) begin
            if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end else if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (mack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + A_ONE;
              end else begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end
          end else if (bitcnt == 4'd8) begin
            unique case (state)
              ST_DEV: begin
                if (dev_match) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  state  <= ST_IDLE;
                  bitcnt <= '0;
                end
              end
              ST_AH: begin
                addr_hi <= shreg[HI_W-1:0];
                sda_oe  <= 1'b1;
              end
              ST_AL: begin
                ptr    <= {addr_hi, shreg};
                sda_oe <= 1'b1;
              end
              ST_WR: begin
                mem_we    <= 1'b1;
                mem_waddr <= ptr;
                mem_wdata <= shreg;
                ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + P_ONE};
                sda_oe    <= 1'b1;
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            unique case (state)
              ST_DEV: begin
                if (rw) begin
                  state  <= ST_RD;
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[7];
                  ptr    <= ptr + A_ONE;
                end else begin
                  state <= ST_AH;
                end
              end
              ST_AH:   state <= ST_AL;
              ST_AL:   state <= ST_WR;
              default: state <= state;
            endcase
          end
        end
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && bitcnt == 4'd0 && !sda_oe));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

  // R5
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);

  // R11
  rd_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && scl_fall && bitcnt == 4'd8 && !start_det && !stop_det)
      |=> !sda_oe);

  // R7
  write_in_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == ST_WR));
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  input  logic       busy_i,
  output logic       sda_oe
);
  logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, ptr;
  logic [7:0]        mem_wdata, rd_data;

  twi_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_eeprom_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_sel   (dev_sel),
    .busy_i    (busy_i),
    .rd_data   (rd_data),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .sda_oe    (sda_oe)
  );

  twi_eeprom_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );
endmodule

// File: tb/sim_twi_eeprom_slave.sv
`timescale 1ns/1ps
module sim_twi_eeprom_slave;
  localparam int ADDR_W = 11;
  localparam int PAGE_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int Q      = 6;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic [2:0] dev_sel = SEL;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  twi_eeprom_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel(dev_sel), .busy_i(busy), .sda_oe(sda_oe)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];
  int ref_ptr = 0;
  logic [7:0] wbuf [PAGE];

  function automatic int page_next(int a);
    return (a & ~(PAGE - 1)) | ((a + 1) & (PAGE - 1));
  endfunction

  function automatic int seq_next(int a);
    return (a + 1) % DEPTH;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); ack = !sda_line; wq(); scl_m = 0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b, output bit rel);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wq(); scl_m = 1; wq(); b[i] = sda_line; wq(); scl_m = 0; wq();
    end
    sda_m = mack ? 1'b0 : 1'b1; wq(); scl_m = 1; wq(); rel = sda_line; wq();
    scl_m = 0; wq(); sda_m = 1;
  endtask

  function automatic logic [7:0] dev_byte(logic [2:0] s, bit r);
    return {4'b1010, s, r};
  endfunction

  // write command: n bytes from wbuf starting at address a (upper bits may be set)
  task automatic write_seq(int a, int n);
    bit ack;
    int p;
    bus_start();
    send_byte(dev_byte(SEL, 0), ack); check(ack, "R3 dev ack", ack, 1);
    send_byte(a[15:8], ack); check(ack, "R6 addr hi ack", ack, 1);
    send_byte(a[7:0], ack);  check(ack, "R6 addr lo ack", ack, 1);
    p = a % DEPTH;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); check(ack, "R5 data ack", ack, 1);
      ref_mem[p] = wbuf[k];
      p = page_next(p);
    end
    ref_ptr = p;
    bus_stop();
  endtask

  task automatic read_bytes(int n, string req);
    logic [7:0] b;
    bit rel;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b, rel);
      check(b === ref_mem[ref_ptr], req, b, ref_mem[ref_ptr]);
      ref_ptr = seq_next(ref_ptr);
    end
    check(rel == 1'b1, "R11 ack slot released", rel, 1);
    bus_stop();
  endtask

  task automatic read_rand(int a, int n, string req);
    bit ack;
    bus_start();
    send_byte(dev_byte(SEL, 0), ack); check(ack, "R8 dev ack", ack, 1);
    send_byte(a[15:8], ack); check(ack, "R6 addr hi ack", ack, 1);
    send_byte(a[7:0], ack);  check(ack, "R6 addr lo ack", ack, 1);
    bus_rstart();
    send_byte(dev_byte(SEL, 1), ack); check(ack, "R8 read dev ack", ack, 1);
    ref_ptr = a % DEPTH;
    read_bytes(n, req);
  endtask

  task automatic read_cur(int n, string req);
    bit ack;
    bus_start();
    send_byte(dev_byte(SEL, 1), ack); check(ack, "R9 dev ack", ack, 1);
    read_bytes(n, req);
  endtask

  task automatic fill_page(int base);
    for (int k = 0; k < PAGE; k++) wbuf[k] = 8'($urandom);
    write_seq(base, PAGE);
  endtask

  initial begin
    bit ack;
    int a, n, sd;
    sd = $urandom(32'd1234);
    for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hxx;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1: byte clocked with no START gets no acknowledge
    send_byte(dev_byte(SEL, 0), ack); check(!ack, "R1 no start no ack", ack, 0);
    bus_stop();

    fill_page(0);
    fill_page(PAGE);
    fill_page(DEPTH - PAGE);

    // R8 random read inside page 0
    read_rand(7, 1, "R8 random read");
    // R9 current address after read
    read_cur(2, "R9 current read");

    // R7 page wrap: 4 bytes from offset 30 of page 1
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
    write_seq(PAGE + 30, 4);
    check(ref_ptr == PAGE + 2, "R7 model pointer", ref_ptr, PAGE + 2);
    read_cur(1, "R9 current after page write");
    read_rand(PAGE, 2, "R7 wrapped bytes");
    read_rand(PAGE + 30, 2, "R7 page tail bytes");

    // R10 whole-array wrap
    read_rand(DEPTH - 2, 4, "R10 sequential wrap");
    read_cur(1, "R9 current after wrap");

    // R6 upper address bits ignored
    a = ((32'hFFFF << ADDR_W) & 32'hFFFF) | 12;
    read_rand(a, 1, "R6 high bits ignored");

    // R3 mismatched select: nack and ignored
    n = ref_ptr;
    bus_start();
    send_byte(dev_byte(~SEL, 0), ack); check(!ack, "R3 mismatch nack", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R3 later byte nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB0 | {4'b0, SEL, 1'b0}, ack); check(!ack, "R3 wrong type nack", ack, 0);
    bus_stop();
    check(ref_ptr == n, "R3 pointer model", ref_ptr, n);
    read_cur(1, "R3 pointer unchanged");

    // R4 busy refuses address
    busy = 1;
    bus_start();
    send_byte(dev_byte(SEL, 0), ack); check(!ack, "R4 busy nack", ack, 0);
    bus_stop();
    busy = 0;

    // R12 / R2 abort mid data byte via START
    bus_start();
    send_byte(dev_byte(SEL, 0), ack); check(ack, "R12 dev ack", ack, 1);
    send_byte(8'h00, ack); check(ack, "R12 hi ack", ack, 1);
    send_byte(8'd5, ack);  check(ack, "R12 lo ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      sda_m = ~ref_mem[5][7 - i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    end
    bus_rstart();
    ref_ptr = 5;
    send_byte(dev_byte(SEL, 1), ack); check(ack, "R2 restart dev ack", ack, 1);
    read_bytes(1, "R12 aborted byte not written");

    // constrained random mix over pages 0 and 1
    for (int t = 0; t < 8; t++) begin
      a = int'($urandom % (2 * PAGE));
      n = 1 + int'($urandom % 3);
      if ($urandom % 2 == 0) begin
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        write_seq(a, n);
        read_cur(1, "R9 random current after write");
      end else begin
        read_rand(a, n, "R10 random sequential");
      end
    end

    done = 1;
    finish_run();
  end
endmodule